// File: doc/BRIEF.md
# Tiny Raster Timing Sequencer

This block produces the raster timing for a 320x240 display mode that is exactly half of 640x480 VGA in each dimension. It runs from the 100 MHz system clock. Each tiny pixel lasts a fixed number of system clocks, 18 by default. A stage counter inside every pixel restarts at zero on each new pixel, and the multi-cycle pixel pipeline uses it to schedule its steps. A one-clock strobe marks the stage by which the pixel colour must be stable. This is stage 9 by default, half of the pixel period, which leaves room for a pipeline that needs five clocks to produce a colour.

The block outputs the current column and row counters. They run through the blanking intervals as well. It also outputs active-video, horizontal and vertical blank, and active-low horizontal and vertical sync. A host processor can count these sync and blank outputs with interrupts to track lines and frames. A synchronous reset returns every counter to zero. The reset may come from a control-register bit or from a push button.

All timing values are parameters. Default line: 320 active pixels, 8 front porch, 48 sync, 24 back porch, 400 in total. Default frame: 240 active lines, 5 front porch, 1 sync, 16 back porch, 262 in total.

Top module: `tiny_raster_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `stage`, `x` and `y` all at zero. Reset is synchronous.
- R2: When reset is not active, `stage` increments by one each clock. From `STAGES-1` it returns to 0.
- R3: `x` changes only on the clock where `stage` wraps from `STAGES-1` to 0. There it increments, or returns to 0 after `H_TOTAL-1`. `y` holds between wraps of `x`.
- R4: `y` increments each time `x` wraps. After `V_TOTAL-1` it returns to 0.
- R5: `hblank` is 1 exactly when `x >= H_ACTIVE`. `vblank` is 1 exactly when `y >= V_ACTIVE`. `active` is 1 exactly when both blanks are 0.
- R6: `hsync_n` is 0 exactly when `H_ACTIVE+H_FP <= x < H_ACTIVE+H_FP+H_SYNC`. Otherwise it is 1.
- R7: `vsync_n` is 0 exactly when `V_ACTIVE+V_FP <= y < V_ACTIVE+V_FP+V_SYNC`. Otherwise it is 1.
- R8: `color_due` is 1 exactly when `stage == VALID_STAGE`. This gives one single-clock pulse per pixel.
- R9: A reset applied partway through a frame restarts the raster from pixel (0,0) at stage 0. It does so regardless of the prior position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stage | output | SW | Clock index within the current tiny pixel |
| x | output | XW | Column counter, 0 to H_TOTAL-1 |
| y | output | YW | Row counter, 0 to V_TOTAL-1 |
| active | output | 1 | Pixel lies in the visible area |
| hblank | output | 1 | Column outside the visible area |
| vblank | output | 1 | Row outside the visible area |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| color_due | output | 1 | Colour-valid deadline strobe |

## Verification
The hardest events to reach are the frame wrap and the vertical sync window. They come only after `STAGES * H_TOTAL * V_TOTAL` clocks, which is almost two million clocks with the default timing. The bench therefore builds the block with a 3-stage pixel, a 10-column line and an 8-row frame. It then drives several complete frames, so every porch, sync edge and wrap occurs many times. A second reset is applied mid-line inside the vertical back porch. This shows that recovery does not depend on where the raster was.

// File: rtl/tiny_raster_seq.sv
module tiny_raster_seq #(
  parameter int STAGES      = 18,
  parameter int VALID_STAGE = 9,
  parameter int H_ACTIVE    = 320,
  parameter int H_FP        = 8,
  parameter int H_SYNC      = 48,
  parameter int H_BP        = 24,
  parameter int V_ACTIVE    = 240,
  parameter int V_FP        = 5,
  parameter int V_SYNC      = 1,
  parameter int V_BP        = 16,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int SW = (STAGES > 1) ? $clog2(STAGES) : 1,
  localparam int XW = $clog2(H_TOTAL),
  localparam int YW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] stage,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          active,
  output logic          hblank,
  output logic          vblank,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          color_due
);

  localparam logic [SW-1:0] S_LAST  = SW'(STAGES - 1);
  localparam logic [SW-1:0] S_DUE   = SW'(VALID_STAGE);
  localparam logic [XW-1:0] X_LAST  = XW'(H_TOTAL - 1);
  localparam logic [XW-1:0] X_VIS   = XW'(H_ACTIVE);
  localparam logic [XW-1:0] X_SYN0  = XW'(H_ACTIVE + H_FP);
  localparam logic [XW-1:0] X_SYN1  = XW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [YW-1:0] Y_LAST  = YW'(V_TOTAL - 1);
  localparam logic [YW-1:0] Y_VIS   = YW'(V_ACTIVE);
  localparam logic [YW-1:0] Y_SYN0  = YW'(V_ACTIVE + V_FP);
  localparam logic [YW-1:0] Y_SYN1  = YW'(V_ACTIVE + V_FP + V_SYNC);

  logic pix_end, line_end, frame_end;

  assign pix_end   = (stage == S_LAST);
  assign line_end  = (x == X_LAST);
  assign frame_end = (y == Y_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      x     <= '0;
      y     <= '0;
    end else begin
      stage <= pix_end ? '0 : stage + 1'b1;
      if (pix_end) begin
        x <= line_end ? '0 : x + 1'b1;
        if (line_end)
          y <= frame_end ? '0 : y + 1'b1;
      end
    end
  end

  assign hblank    = (x >= X_VIS);
  assign vblank    = (y >= Y_VIS);
  assign active    = !(hblank || vblank);
  assign hsync_n   = !((x >= X_SYN0) && (x < X_SYN1));
  assign vsync_n   = !((y >= Y_SYN0) && (y < Y_SYN1));
  assign color_due = (stage == S_DUE);

endmodule

// File: rtl/tiny_raster_seq_chk.sv
module tiny_raster_seq_chk #(
  parameter int STAGES   = 18,
  parameter int H_ACTIVE = 320,
  parameter int H_FP     = 8,
  parameter int H_TOTAL  = 400,
  parameter int V_ACTIVE = 240,
  parameter int V_FP     = 5,
  parameter int V_TOTAL  = 262,
  parameter int SW       = 5,
  parameter int XW       = 9,
  parameter int YW       = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] stage,
  input logic [XW-1:0] x,
  input logic [YW-1:0] y,
  input logic          active,
  input logic          hblank,
  input logic          vblank,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          color_due
);

  localparam logic [SW-1:0] S_LAST = SW'(STAGES - 1);
  localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
  localparam logic [XW-1:0] X_VIS  = XW'(H_ACTIVE);
  localparam logic [XW-1:0] X_SYN0 = XW'(H_ACTIVE + H_FP);
  localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);
  localparam logic [YW-1:0] Y_SYN0 = YW'(V_ACTIVE + V_FP);

  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (stage == '0 && x == '0 && y == '0));

  a_r2_stage_step: assert property (@(posedge clk) disable iff (rst)
    (stage != S_LAST) |=> (stage == $past(stage) + 1'b1));

  a_r2_stage_wrap: assert property (@(posedge clk) disable iff (rst)
    (stage == S_LAST) |=> (stage == '0));

  a_r3_hold_pos: assert property (@(posedge clk) disable iff (rst)
    (stage != S_LAST) |=> ($stable(x) && $stable(y)));

  a_r3_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (stage == S_LAST && x == X_LAST) |=> (x == '0 && y != $past(y)));

  a_r4_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (stage == S_LAST && x == X_LAST && y == Y_LAST) |=> (y == '0));

  a_r5_hblank_start: assert property (@(posedge clk) disable iff (rst)
    $rose(hblank) |-> (x == X_VIS && !active));

  a_r6_hsync_start: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> (x == X_SYN0));

  a_r7_vsync_start: assert property (@(posedge clk) disable iff (rst)
    $fell(vsync_n) |-> (y == Y_SYN0 && vblank));

  a_r8_due_single: assert property (@(posedge clk) disable iff (rst)
    color_due |=> !color_due);

endmodule

bind tiny_raster_seq tiny_raster_seq_chk #(
  .STAGES(STAGES), .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_TOTAL(H_TOTAL),
  .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_TOTAL(V_TOTAL),
  .SW(SW), .XW(XW), .YW(YW)
) u_chk (
  .clk(clk), .rst(rst), .stage(stage), .x(x), .y(y), .active(active),
  .hblank(hblank), .vblank(vblank), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .color_due(color_due)
);

// File: tb/tiny_raster_seq_tb.sv
module tiny_raster_seq_tb;
  localparam int ST = 3, VS = 1;
  localparam int HA = 6, HF = 1, HS = 2, HB = 1, HT = HA + HF + HS + HB;
  localparam int VA = 4, VF = 1, VSY = 1, VB = 2, VT = VA + VF + VSY + VB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] stage;
  logic [3:0] x;
  logic [2:0] y;
  logic active, hblank, vblank, hsync_n, vsync_n, color_due;

  tiny_raster_seq #(
    .STAGES(ST), .VALID_STAGE(VS),
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VSY), .V_BP(VB)
  ) u_dut (
    .clk(clk), .rst(rst), .stage(stage), .x(x), .y(y), .active(active),
    .hblank(hblank), .vblank(vblank), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .color_due(color_due)
  );

  always #4 clk = ~clk;

  typedef struct {
    int stg, px, py, hb, vb, act, hs, vs, due;
    bit after_rst;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0;
  int m_stg = 0, m_x = 0, m_y = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r);
    exp_t e;
    @(negedge clk);
    rst = r;
    @(posedge clk);
    if (r) begin
      m_stg = 0; m_x = 0; m_y = 0;
    end else if (m_stg == ST - 1) begin
      m_stg = 0;
      if (m_x == HT - 1) begin
        m_x = 0;
        m_y = (m_y == VT - 1) ? 0 : m_y + 1;
      end else m_x++;
    end else m_stg++;
    e.stg = m_stg; e.px = m_x; e.py = m_y;
    e.hb  = (m_x >= HA); e.vb = (m_y >= VA);
    e.act = !(e.hb || e.vb);
    e.hs  = !((m_x >= HA + HF) && (m_x < HA + HF + HS));
    e.vs  = !((m_y >= VA + VF) && (m_y < VA + VF + VSY));
    e.due = (m_stg == VS);
    e.after_rst = r;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.after_rst) begin
          chk("R1/R9 stage", int'(stage), e.stg);
          chk("R1/R9 x", int'(x), e.px);
          chk("R1/R9 y", int'(y), e.py);
        end else begin
          chk("R2 stage", int'(stage), e.stg);
          chk("R3 x", int'(x), e.px);
          chk("R4 y", int'(y), e.py);
        end
        chk("R5 hblank", int'(hblank), e.hb);
        chk("R5 vblank", int'(vblank), e.vb);
        chk("R5 active", int'(active), e.act);
        chk("R6 hsync_n", int'(hsync_n), e.hs);
        chk("R7 vsync_n", int'(vsync_n), e.vs);
        chk("R8 color_due", int'(color_due), e.due);
      end
    end
  end

  initial begin : driver
    step(1'b1);
    step(1'b1);
    for (int i = 0; i < 3 * ST * HT * VT + 7; i++) step(1'b0);
    // R9: reset mid-line inside vertical back porch
    while (!(m_y == VT - 1 && m_x == 3 && m_stg == 1)) step(1'b0);
    step(1'b1);
    for (int i = 0; i < ST * HT * VT + 5; i++) step(1'b0);
    step(1'b1);
    step(1'b1);
    step(1'b1);
    for (int i = 0; i < 50; i++) step(1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule